// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the 32-bit bus time of a node on an isochronous serial bus. The value has three mixed-radix fields. A 12-bit offset counts ticks of the local bus clock. A 13-bit count numbers the 125 µs cycles within one second. A 7-bit seconds field wraps every 128 seconds. When the node is cycle master, the timer runs freely, and the transmit path samples its current value to build each cycle-start message.

When the node is not cycle master, a parser outside this block passes the time carried by each received cycle start as a 32-bit word with a valid strobe. The timer adopts that word. Between cycle starts it keeps counting by itself, so local time stays valid if a cycle start is lost. When a received value does not match the local seconds and count, the block raises a one-cycle inconsistency pulse. Loading does not stop when that happens.

The block also gives a one-cycle pulse at each cycle boundary and another each time the seconds field passes a 64-second boundary. An external 8 kHz reference can be selected in place of the internal divide-by-3072 rule to mark cycle boundaries.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset, `time_out` is zero and `cycle_tick`, `sec64_tick` and `mismatch` are low.
- R2: With `run_en` high, `ext_sel` low and no load, the offset (bits 11:0) rises by one on each clock. When it is at 3071, the next clock sets it to 0 and raises the count (bits 24:12) by one.
- R3: When the count is at 7999 and an offset wrap occurs, the count goes to 0 and the seconds (bits 31:25) rise by one. The seconds wrap from 127 to 0.
- R4: With `run_en` low and no load, `time_out` does not change.
- R5: When `cs_valid` is high and `master` is low, `time_out` equals `cs_time` on the next clock, whatever the value of `run_en`.
- R6: When `master` is high, `cs_valid` and `cs_time` are ignored: the timer keeps counting and `mismatch` stays low.
- R7: `mismatch` is high for exactly the one cycle after a load whose bits 31:12 differ from `time_out` at that moment. A difference in the offset bits alone gives no pulse.
- R8: `cycle_tick` is high for the one cycle in which `time_out` first shows a count raised by an offset wrap. A load never raises it.
- R9: `sec64_tick` is high for the one cycle after bit 31 of `time_out` (bit 6 of the seconds) changes, whether the change came from counting or from a load.
- R10: With `ext_sel` high, the offset wraps only on a clock where `ext_cycle` is high and was low at the previous clock. Between such edges the offset rises and then holds at 3071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables counting |
| master | input | 1 | Node is cycle master; received times are ignored |
| ext_sel | input | 1 | Selects the external cycle reference |
| ext_cycle | input | 1 | External 8 kHz cycle reference |
| cs_valid | input | 1 | Strobe: a received cycle-start time is present |
| cs_time | input | 32 | Received time {seconds, count, offset} |
| time_out | output | 32 | Current time {seconds[31:25], count[24:12], offset[11:0]} |
| cycle_tick | output | 1 | Pulse on each count increment |
| sec64_tick | output | 1 | Pulse on a change of seconds bit 6 |
| mismatch | output | 1 | Pulse when received seconds and count differ from local |

## Verification
Seconds and 64-second events come only after millions of free-running cycles, which is too many to run. The stimulus instead loads times just below each boundary through the received-time path in non-master mode. It then switches counting on and lets the timer cross 7999/3071 and 127/7999/3071 by itself. The external-reference case is handled the same way: the offset is parked just below 3071 so the hold at the top and an early wrap on an edge are both seen.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int SEC_W = 7;
  localparam int CNT_W = 13;
  localparam int OFF_W = 12;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } ctime_t;

  // Next count value on a cycle boundary
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] top);
    return (c == top) ? '0 : c + 1'b1;
  endfunction

  // Next offset value: wraps on boundary, saturates at top otherwise
  function automatic logic [OFF_W-1:0] off_step(input logic [OFF_W-1:0] o,
                                                input logic [OFF_W-1:0] top,
                                                input logic wrap);
    if (wrap) return '0;
    return (o == top) ? o : o + 1'b1;
  endfunction
endpackage

// File: rtl/ctmr_edge.sv
module ctmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ref_in;
  end

  assign rise = ref_in & ~prev_q;
endmodule

// File: rtl/ctmr_fields.sv
module ctmr_fields
  import ctmr_pkg::*;
#(
  parameter int OFF_LIMIT = 3072,
  parameter int CNT_LIMIT = 8000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  logic   load,
  input  ctime_t load_val,
  input  logic   ext_sel,
  input  logic   ext_rise,
  output ctime_t cur,
  output ctime_t nxt,
  output logic   off_wrap
);
  localparam logic [OFF_W-1:0] OFF_TOP = OFF_W'(OFF_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_LIMIT - 1);

  logic boundary;

  always_comb begin
    boundary = ext_sel ? ext_rise : (cur.off == OFF_TOP);
    nxt      = cur;
    off_wrap = 1'b0;
    if (load) begin
      nxt = load_val;
    end else if (run_en) begin
      off_wrap = boundary;
      nxt.off  = off_step(cur.off, OFF_TOP, boundary);
      if (boundary) begin
        nxt.cnt = cnt_step(cur.cnt, CNT_TOP);
        if (cur.cnt == CNT_TOP) nxt.sec = cur.sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/ctmr_events.sv
module ctmr_events
  import ctmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctime_t cur,
  input  ctime_t nxt,
  input  logic   off_wrap,
  input  logic   load,
  input  ctime_t load_val,
  output logic   cyc_pulse,
  output logic   s64_pulse,
  output logic   miss_pulse
);
  logic differs;
  assign differs = (load_val.sec != cur.sec) || (load_val.cnt != cur.cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_pulse  <= 1'b0;
      s64_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
    end else begin
      cyc_pulse  <= off_wrap;
      s64_pulse  <= nxt.sec[SEC_W-1] ^ cur.sec[SEC_W-1];
      miss_pulse <= load & differs;
    end
  end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import ctmr_pkg::*;
#(
  parameter int OFF_LIMIT = 3072,
  parameter int CNT_LIMIT = 8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        master,
  input  logic        ext_sel,
  input  logic        ext_cycle,
  input  logic        cs_valid,
  input  logic [31:0] cs_time,
  output logic [31:0] time_out,
  output logic        cycle_tick,
  output logic        sec64_tick,
  output logic        mismatch
);
  ctime_t cur, nxt;
  logic   load_evt, ext_rise, off_wrap;

  assign load_evt = cs_valid & ~master;

  ctmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ref_in(ext_cycle), .rise(ext_rise)
  );

  ctmr_fields #(.OFF_LIMIT(OFF_LIMIT), .CNT_LIMIT(CNT_LIMIT)) u_fields (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(load_evt),
    .load_val(ctime_t'(cs_time)), .ext_sel(ext_sel), .ext_rise(ext_rise),
    .cur(cur), .nxt(nxt), .off_wrap(off_wrap)
  );

  ctmr_events u_events (
    .clk(clk), .rst_n(rst_n), .cur(cur), .nxt(nxt), .off_wrap(off_wrap),
    .load(load_evt), .load_val(ctime_t'(cs_time)),
    .cyc_pulse(cycle_tick), .s64_pulse(sec64_tick), .miss_pulse(mismatch)
  );

  assign time_out = cur;
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        master,
  input logic        ext_sel,
  input logic        cs_valid,
  input logic [31:0] cs_time,
  input logic [31:0] time_out,
  input logic        cycle_tick,
  input logic        sec64_tick,
  input logic        mismatch,
  input logic        ext_rise,
  input logic        load_evt
);
  // R5
  load_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && !master) |=> time_out == $past(cs_time));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_evt) |=> $stable(time_out));

  // R6
  master_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && run_en && !ext_sel && time_out[11:0] != 12'd3071)
      |=> time_out[11:0] == $past(time_out[11:0]) + 12'd1);

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_out[24:12] < 13'd8000);

  // R8
  tick_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick |-> time_out[11:0] == 12'd0);

  // R9
  sec64_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec64_tick |-> time_out[31] != $past(time_out[31]));

  // R7
  mismatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> $past(cs_valid && !master));

  // R10
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && run_en && !load_evt && time_out[11:0] == 12'd3071 && !ext_rise)
      |=> time_out[11:0] == 12'd3071);
endmodule

bind bus_cycle_timer ctmr_checker u_ctmr_checker (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .master(master),
  .ext_sel(ext_sel), .cs_valid(cs_valid), .cs_time(cs_time),
  .time_out(time_out), .cycle_tick(cycle_tick), .sec64_tick(sec64_tick),
  .mismatch(mismatch), .ext_rise(ext_rise), .load_evt(load_evt)
);

// File: tb/bus_cycle_timer_bench.sv
module bus_cycle_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, master = 1'b0, ext_sel = 1'b0, ext_cycle = 1'b0;
  logic        cs_valid = 1'b0;
  logic [31:0] cs_time = '0;
  logic [31:0] time_out;
  logic        cycle_tick, sec64_tick, mismatch;

  int checks = 0, errors = 0;

  typedef struct {
    logic [31:0] t;
    logic        syn, s64, mis;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  int ms = 0, mc = 0, mo = 0;
  bit m_prev_ext = 0;

  always #10 clk = ~clk;

  bus_cycle_timer u_bus_cycle_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .master(master),
    .ext_sel(ext_sel), .ext_cycle(ext_cycle), .cs_valid(cs_valid),
    .cs_time(cs_time), .time_out(time_out), .cycle_tick(cycle_tick),
    .sec64_tick(sec64_tick), .mismatch(mismatch)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(bit run, bit mst, bit esel, bit ext, bit csv,
                      logic [31:0] cst, string tag);
    exp_t e;
    int ns, nc, no;
    bit wrap, rise, ld;
    run_en = run; master = mst; ext_sel = esel; ext_cycle = ext;
    cs_valid = csv; cs_time = cst;
    ld   = csv && !mst;
    rise = ext && !m_prev_ext;
    ns = ms; nc = mc; no = mo;
    e.syn = 0;
    e.mis = ld && ((int'(cst[31:25]) != ms) || (int'(cst[24:12]) != mc));
    if (ld) begin
      ns = int'(cst[31:25]); nc = int'(cst[24:12]); no = int'(cst[11:0]);
    end else if (run) begin
      wrap = esel ? rise : (mo == 3071);
      if (wrap) begin
        no = 0; nc = mc + 1; e.syn = 1;
        if (nc == 8000) begin nc = 0; ns = (ms + 1) % 128; end
      end else if (mo < 3071) begin
        no = mo + 1;
      end
    end
    e.s64 = ((ns / 64) % 2) != ((ms / 64) % 2);
    e.t   = pack(ns, nc, no);
    e.tag = tag;
    sb.push_back(e);
    ms = ns; mc = nc; mo = no; m_prev_ext = ext;
    @(negedge clk);
  endtask

  // monitor: compare outputs after each active edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "time_out",   time_out,          e.t);
      check(e.tag, "cycle_tick", {31'd0, cycle_tick}, {31'd0, e.syn});
      check(e.tag, "sec64_tick", {31'd0, sec64_tick}, {31'd0, e.s64});
      check(e.tag, "mismatch",   {31'd0, mismatch},   {31'd0, e.mis});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "time_out", time_out, 32'd0);
    check("R1", "pulses", {29'd0, cycle_tick, sec64_tick, mismatch}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 plain counting from zero
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, '0, "R2");
    // R5 and R7: load a differing time near an offset wrap
    step(1, 0, 0, 0, 1, pack(3, 10, 3068), "R5/R7");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, '0, "R2/R8");
    // R4 hold
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, '0, "R4");
    // R7 offset-only difference gives no pulse; R5 load while stopped
    step(0, 0, 0, 0, 1, pack(ms, mc, 5), "R7");
    step(0, 0, 0, 0, 1, pack(20, 100, 7), "R5");
    // R3 and R9: count wrap moves seconds 63 -> 64
    step(1, 0, 0, 0, 1, pack(63, 7999, 3070), "R3");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, '0, "R3/R9");
    // R3 and R9: seconds wrap 127 -> 0
    step(1, 0, 0, 0, 1, pack(127, 7999, 3071), "R3");
    for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 0, '0, "R3/R9");
    // R9 via a load crossing bit 6 back
    step(1, 0, 0, 0, 1, pack(70, 1, 1), "R9");
    // R6 master ignores received time
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, pack(5, 5, 5), "R6");
    // R10 external reference: hold at top, then wrap on a rising edge
    step(1, 0, 1, 0, 1, pack(2, 40, 3069), "R10");
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, '0, "R10");
    step(1, 0, 1, 1, 0, '0, "R10");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, '0, "R10");
    step(1, 0, 1, 0, 0, '0, "R10");
    step(1, 0, 1, 1, 0, '0, "R10");
    // R10 internal rule ignores edges when not selected
    step(1, 0, 0, 0, 0, '0, "R10");
    step(1, 0, 0, 1, 0, '0, "R10");
    step(1, 0, 0, 0, 0, '0, "R2");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule